// File: doc/BRIEF.md
# Packet Buffer Allocation Command Unit

This unit keeps track of a small pool of packet buffers, each named by a 6-bit packet number. A host drives it through an 8-bit command word. The upper three bits select an operation. The lower five bits give the size of an allocation as a page count minus one. Each accepted command keeps the unit busy for a fixed number of cycles. The command takes effect on the last busy cycle. The unit answers allocations through a 16-bit result word. It also presents a 16-bit queue-status word, which shows the heads of its receive queue and its transmit-completion queue.

Receive logic pushes the numbers of arrived packets into the receive queue. The host can drop an arrived packet from the queue, or drop it and release its buffer. To transmit, the host allocates a buffer and queues the packet number toward the transmitter. The transmitter takes numbers from that queue and later pushes each finished number into the completion queue. The host then releases the finished packet by number. An allocation that cannot be met right away is flagged as failed and held. It is granted automatically, with a one-cycle completion pulse, as soon as enough buffers and pages have been released.

Top module: `pkt_alloc_unit`

## Requirements
- R1: A command write while `cmd_busy` is low is accepted. `cmd_busy` is then high for exactly EXEC_CYCLES (default 2) cycles, and the command's effect is visible in the cycle `cmd_busy` falls. Command writes while `cmd_busy` is high are ignored.
- R2: Allocate is operation 1 (`cmd_wdata[7:5]`). It requests `cmd_wdata[4:0]`+1 pages. On success it grants the lowest free packet number out of NUM_PKTS (default 8). `alloc_result` then reads `{1'b0, 9'b0, pnr}`, where the low byte holds the packet number and bits 7:6 read zero.
- R3: An allocation fails in three cases: no packet number is free, the requested pages would push the total in use above TOTAL_PAGES (default 24), or the request exceeds MAX_PAGES (default 8). On failure, `alloc_result[15]` reads 1 and the packet-number field is left unchanged. An oversized request is never retried.
- R4: An allocation that fails for lack of packets or pages stays pending. A later allocation command replaces it. In the first idle cycle in which it fits, it is granted. The result then shows the new packet number with bit 15 clear, and `alloc_done` pulses high for exactly one cycle.
- R5: Operation 3 removes the head of the receive queue and leaves that packet allocated.
- R6: Operation 4 removes the head of the receive queue and releases that packet's buffer and pages.
- R7: Operation 5 releases the packet whose number is held in the packet-number register. That register is loaded through `pnr_we`/`pnr_wdata` or by a successful grant. If the completion-queue head equals that number, the head is removed as well.
- R8: Operation 6 appends the packet-number register to the transmit queue. `tx_req_valid`/`tx_req_pnr` present its head, and `tx_take` removes the head.
- R9: Operation 7 empties the transmit queue and the completion queue. Packet allocations are left unchanged.
- R10: Operation 2 releases every packet, empties all three queues, cancels a pending allocation and clears `alloc_result` to 0.
- R11: `fifo_ports` bit 15 is 1 when the receive queue is empty, and bits 13:8 hold the receive head. Bit 7 is 1 when the completion queue is empty, and bits 5:0 hold the completion head. All other bits, and the head fields of empty queues, read 0.
- R12: After reset, `cmd_busy`=0, `alloc_result`=0, `fifo_ports`=16'h8080, `tx_req_valid`=0 and `alloc_done`=0.
- R13: Each queue holds NUM_PKTS entries. A push into a full queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Operation in [7:5], page count minus one in [4:0] |
| cmd_busy | output | 1 | Command in progress |
| pnr_we | input | 1 | Packet-number register write strobe |
| pnr_wdata | input | 6 | Packet-number register write value |
| alloc_result | output | 16 | Failure flag [15], packet number [5:0] |
| fifo_ports | output | 16 | Queue status and heads |
| rx_push | input | 1 | Push into receive queue |
| rx_push_pnr | input | 6 | Number of the received packet |
| done_push | input | 1 | Push into completion queue |
| done_push_pnr | input | 6 | Number of the transmitted packet |
| tx_req_valid | output | 1 | Transmit queue not empty |
| tx_req_pnr | output | 6 | Transmit queue head |
| tx_take | input | 1 | Remove the transmit queue head |
| alloc_done | output | 1 | One-cycle pulse when a pending allocation is granted |

## Verification
Allocation is tried with three kinds of request, each failing in a different way:
- A series of page sizes that first fits and then exceeds the page budget. This separates the page check from the packet-number check.
- Enough one-page requests to use up every packet number.
- An oversized request. This shows that such a request fails without being held.

Release is tried in several orders. Buffers are released through both receive-drop variants and through the by-number release, with gaps left in the middle of the pool. Later grants then show whether the lowest free number is chosen and whether a plain drop left its packet allocated.

Queue traffic fills the receive queue past its depth. It also mixes transmit takes with completion pushes and the transmit reset. A reference model compares every output on every clock. This catches off-by-one timing in the busy window and in the deferred grant.

// File: rtl/pau_pkg.sv
package pau_pkg;
  localparam int PNR_W = 6;
  localparam int SZ_W  = 5;

  typedef logic [PNR_W-1:0] pnr_t;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ALLOC  = 3'd1,
    OP_RESET  = 3'd2,
    OP_RXDROP = 3'd3,
    OP_RXFREE = 3'd4,
    OP_FREE   = 3'd5,
    OP_ENQ    = 3'd6,
    OP_TXRST  = 3'd7
  } op_e;
endpackage

// File: rtl/pau_fifo.sv
module pau_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_n, wr_q, wr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rd_q];

  always_comb begin
    rd_n  = rd_q;
    wr_n  = wr_q;
    cnt_n = cnt_q;
    if (clr) begin
      rd_n  = '0;
      wr_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = step(wr_q);
      if (do_pop)  rd_n = step(rd_q);
      if (do_push && !do_pop)      cnt_n = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/pau_pool.sv
module pau_pool
  import pau_pkg::*;
#(
  parameter int NUM_PKTS    = 8,
  parameter int MAX_PAGES   = 8,
  parameter int TOTAL_PAGES = 24
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr_all,
  input  logic [$clog2(MAX_PAGES+1)-1:0]   q_pages,
  output logic                             q_ok,
  output pnr_t                             q_pnr,
  input  logic                             grant,
  input  logic                             free_req,
  input  pnr_t                             free_pnr
);
  localparam int IW   = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1;
  localparam int PG_W = $clog2(MAX_PAGES + 1);
  localparam int UW   = $clog2(TOTAL_PAGES + 1);

  logic [NUM_PKTS-1:0] map_q, map_n;
  logic [PG_W-1:0]     pg_q [NUM_PKTS];
  logic [UW-1:0]       used_q, used_n;
  logic [IW-1:0]       low_idx, fr_idx;
  logic                any_free, free_hit;

  // priority search: lowest clear bit of the allocation map
  always_comb begin
    any_free = 1'b0;
    low_idx  = '0;
    for (int i = NUM_PKTS - 1; i >= 0; i--) begin
      if (!map_q[i]) begin
        any_free = 1'b1;
        low_idx  = IW'(i);
      end
    end
  end

  assign q_pnr    = pnr_t'(low_idx);
  assign q_ok     = any_free && (int'(used_q) + int'(q_pages) <= TOTAL_PAGES);
  assign fr_idx   = free_pnr[IW-1:0];
  assign free_hit = free_req && (int'(free_pnr) < NUM_PKTS) && map_q[fr_idx];

  always_comb begin
    map_n  = map_q;
    used_n = used_q;
    if (clr_all) begin
      map_n  = '0;
      used_n = '0;
    end else begin
      if (grant) begin
        map_n[low_idx] = 1'b1;
        used_n         = used_n + UW'(q_pages);
      end
      if (free_hit) begin
        map_n[fr_idx] = 1'b0;
        used_n        = used_n - UW'(pg_q[fr_idx]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= '0;
      used_q <= '0;
    end else begin
      map_q  <= map_n;
      used_q <= used_n;
    end
  end

  // per-packet page counts: data only, meaningful while the map bit is set
  for (genvar g = 0; g < NUM_PKTS; g++) begin : g_pages
    always_ff @(posedge clk) begin
      if (grant && !clr_all && (low_idx == IW'(g))) pg_q[g] <= q_pages;
    end
  end
endmodule

// File: rtl/pkt_alloc_unit.sv
module pkt_alloc_unit
  import pau_pkg::*;
#(
  parameter int NUM_PKTS    = 8,
  parameter int MAX_PAGES   = 8,
  parameter int TOTAL_PAGES = 24,
  parameter int EXEC_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [7:0]  cmd_wdata,
  output logic        cmd_busy,
  input  logic        pnr_we,
  input  logic [5:0]  pnr_wdata,
  output logic [15:0] alloc_result,
  output logic [15:0] fifo_ports,
  input  logic        rx_push,
  input  logic [5:0]  rx_push_pnr,
  input  logic        done_push,
  input  logic [5:0]  done_push_pnr,
  output logic        tx_req_valid,
  output logic [5:0]  tx_req_pnr,
  input  logic        tx_take,
  output logic        alloc_done
);
  localparam int CW   = $clog2(EXEC_CYCLES + 1);
  localparam int PG_W = $clog2(MAX_PAGES + 1);

  logic [CW-1:0]   cnt_q, cnt_n;
  op_e             op_q, op_n;
  logic [SZ_W-1:0] sz_q, sz_n;
  pnr_t            pnr_q, pnr_n;
  logic            fail_q, fail_n, pend_q, pend_n, done_q, done_n;
  logic [PG_W-1:0] ppg_q, ppg_n, q_pages;

  logic       exec, x_alloc, x_reset, x_rxdrop, x_rxfree, x_free, x_enq, x_txrst;
  logic [5:0] req_pages;
  logic       oversize, q_ok, pend_go, grant;
  pnr_t       q_pnr;
  logic       rx_empty, rx_full, dn_empty, dn_full, tx_empty, tx_full;
  pnr_t       rx_head, dn_head, tx_head;
  logic       dn_pop, free_req;
  pnr_t       free_pnr;

  assign exec     = (cnt_q == CW'(1));
  assign x_alloc  = exec && (op_q == OP_ALLOC);
  assign x_reset  = exec && (op_q == OP_RESET);
  assign x_rxdrop = exec && (op_q == OP_RXDROP);
  assign x_rxfree = exec && (op_q == OP_RXFREE);
  assign x_free   = exec && (op_q == OP_FREE);
  assign x_enq    = exec && (op_q == OP_ENQ);
  assign x_txrst  = exec && (op_q == OP_TXRST);

  assign req_pages = {1'b0, sz_q} + 6'd1;
  assign oversize  = int'(sz_q) >= MAX_PAGES;
  assign q_pages   = x_alloc ? PG_W'(req_pages) : ppg_q;
  assign pend_go   = pend_q && !exec && q_ok;
  assign grant     = (x_alloc && q_ok && !oversize) || pend_go;

  assign dn_pop   = x_free && !dn_empty && (dn_head == pnr_q);
  assign free_req = (x_rxfree && !rx_empty) || x_free;
  assign free_pnr = x_rxfree ? rx_head : pnr_q;

  pau_pool #(
    .NUM_PKTS(NUM_PKTS), .MAX_PAGES(MAX_PAGES), .TOTAL_PAGES(TOTAL_PAGES)
  ) u_pool (
    .clk(clk), .rst_n(rst_n), .clr_all(x_reset), .q_pages(q_pages),
    .q_ok(q_ok), .q_pnr(q_pnr), .grant(grant),
    .free_req(free_req), .free_pnr(free_pnr)
  );

  pau_fifo #(.DEPTH(NUM_PKTS), .W(PNR_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(x_reset), .push(rx_push), .din(rx_push_pnr),
    .pop(x_rxdrop || x_rxfree), .dout(rx_head), .empty(rx_empty), .full(rx_full)
  );

  pau_fifo #(.DEPTH(NUM_PKTS), .W(PNR_W)) u_doneq (
    .clk(clk), .rst_n(rst_n), .clr(x_reset || x_txrst), .push(done_push),
    .din(done_push_pnr), .pop(dn_pop), .dout(dn_head), .empty(dn_empty), .full(dn_full)
  );

  pau_fifo #(.DEPTH(NUM_PKTS), .W(PNR_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(x_reset || x_txrst), .push(x_enq), .din(pnr_q),
    .pop(tx_take), .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  // command sequencer and result register: next state
  always_comb begin
    cnt_n  = cnt_q;
    op_n   = op_q;
    sz_n   = sz_q;
    pnr_n  = pnr_q;
    fail_n = fail_q;
    pend_n = pend_q;
    ppg_n  = ppg_q;
    done_n = pend_go;

    if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end else if (cmd_we) begin
      cnt_n = CW'(EXEC_CYCLES);
      op_n  = op_e'(cmd_wdata[7:5]);
      sz_n  = cmd_wdata[4:0];
    end

    if (x_alloc) begin
      if (q_ok && !oversize) begin
        pnr_n  = q_pnr;
        fail_n = 1'b0;
        pend_n = 1'b0;
      end else begin
        fail_n = 1'b1;
        pend_n = !oversize;
        ppg_n  = PG_W'(req_pages);
      end
    end else if (pend_go) begin
      pnr_n  = q_pnr;
      fail_n = 1'b0;
      pend_n = 1'b0;
    end else if (x_reset) begin
      pnr_n  = '0;
      fail_n = 1'b0;
      pend_n = 1'b0;
    end else if (pnr_we) begin
      pnr_n = pnr_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      op_q   <= OP_NOP;
      sz_q   <= '0;
      pnr_q  <= '0;
      fail_q <= 1'b0;
      pend_q <= 1'b0;
      ppg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      op_q   <= op_n;
      sz_q   <= sz_n;
      pnr_q  <= pnr_n;
      fail_q <= fail_n;
      pend_q <= pend_n;
      ppg_q  <= ppg_n;
      done_q <= done_n;
    end
  end

  assign cmd_busy     = (cnt_q != '0);
  assign alloc_done   = done_q;
  assign alloc_result = {fail_q, 9'b0, pnr_q};
  assign fifo_ports   = {rx_empty, 1'b0, (rx_empty ? 6'd0 : rx_head),
                         dn_empty, 1'b0, (dn_empty ? 6'd0 : dn_head)};
  assign tx_req_valid = !tx_empty;
  assign tx_req_pnr   = tx_empty ? 6'd0 : tx_head;
endmodule

// File: rtl/pau_chk.sv
module pau_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic        cmd_busy,
  input logic [15:0] alloc_result,
  input logic [15:0] fifo_ports,
  input logic        tx_req_valid,
  input logic        tx_take,
  input logic        alloc_done
);
  // R1: an idle-time write starts a busy window
  a_r1_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !cmd_busy) |=> cmd_busy);

  // R4: completion pulse is one cycle wide
  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |=> !alloc_done);

  // R4: completion comes with a successful result
  a_r4_done_clears_fail: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> !alloc_result[15]);

  // R8: transmit head only leaves on a take or a command
  a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_valid && !tx_take && !cmd_busy) |=> tx_req_valid);

  // R5: receive queue only drains through a command
  a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_ports[15] && !cmd_busy) |=> !fifo_ports[15]);
endmodule

bind pkt_alloc_unit pau_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_busy(cmd_busy),
  .alloc_result(alloc_result), .fifo_ports(fifo_ports),
  .tx_req_valid(tx_req_valid), .tx_take(tx_take), .alloc_done(alloc_done)
);

// File: tb/tb_pkt_alloc_unit.sv
`timescale 1ns/1ps
module tb_pkt_alloc_unit;
  localparam int NP = 8, MAXP = 8, TOT = 24, EXEC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0, pnr_we = 0, rx_push = 0, done_push = 0, tx_take = 0;
  logic [7:0] cmd_wdata = 0;
  logic [5:0] pnr_wdata = 0, rx_push_pnr = 0, done_push_pnr = 0;
  logic cmd_busy, tx_req_valid, alloc_done;
  logic [15:0] alloc_result, fifo_ports;
  logic [5:0] tx_req_pnr;

  always #10 clk = ~clk;

  pkt_alloc_unit #(.NUM_PKTS(NP), .MAX_PAGES(MAXP), .TOTAL_PAGES(TOT), .EXEC_CYCLES(EXEC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy),
    .pnr_we(pnr_we), .pnr_wdata(pnr_wdata), .alloc_result(alloc_result), .fifo_ports(fifo_ports),
    .rx_push(rx_push), .rx_push_pnr(rx_push_pnr), .done_push(done_push),
    .done_push_pnr(done_push_pnr), .tx_req_valid(tx_req_valid), .tx_req_pnr(tx_req_pnr),
    .tx_take(tx_take), .alloc_done(alloc_done));

  int tests = 0, fails = 0, cyc = 0, done_seen = 0;
  bit cmp_en = 0, finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_busy, m_pnr, m_pp, m_used;
  bit [7:0] m_cmd;
  bit m_fail, m_pend, m_done;
  bit m_al [NP];
  int m_pg [NP];
  int rxq[$], dq[$], txq[$];

  function automatic int lowest_free();
    for (int i = 0; i < NP; i++) if (!m_al[i]) return i;
    return -1;
  endfunction

  function automatic void m_release(int p);
    if (p < NP && m_al[p]) begin m_al[p] = 0; m_used -= m_pg[p]; end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cmd = 0; m_pnr = 0; m_pp = 0; m_used = 0;
      m_fail = 0; m_pend = 0; m_done = 0;
      for (int i = 0; i < NP; i++) begin m_al[i] = 0; m_pg[i] = 0; end
      rxq.delete(); dq.delete(); txq.delete();
    end else begin
      bit ex, ok, pgo, over, rxne, dne, txne, rxf, df, txf;
      int op, sz, qp, lf, rxh, dh, oldp;
      ex = (m_busy == 1); op = m_cmd[7:5]; sz = m_cmd[4:0];
      over = (sz + 1) > MAXP;
      qp = (ex && op == 1) ? sz + 1 : m_pp;
      lf = lowest_free();
      ok = (lf >= 0) && (m_used + qp <= TOT);
      pgo = m_pend && !ex && ok;
      rxne = rxq.size() > 0; dne = dq.size() > 0; txne = txq.size() > 0;
      rxf = rxq.size() == NP; df = dq.size() == NP; txf = txq.size() == NP;
      rxh = rxne ? rxq[0] : 0; dh = dne ? dq[0] : 0; oldp = m_pnr;
      m_done = pgo;
      if (m_busy != 0) m_busy--;
      else if (cmd_we) begin m_busy = EXEC; m_cmd = cmd_wdata; end
      if (ex && op == 4 && rxne) m_release(rxh);
      if (ex && op == 5) m_release(oldp);
      if (ex && op == 2) rxq.delete();
      else begin
        if (ex && (op == 3 || op == 4) && rxne) void'(rxq.pop_front());
        if (rx_push && !rxf) rxq.push_back(int'(rx_push_pnr));
      end
      if (ex && (op == 2 || op == 7)) begin dq.delete(); txq.delete(); end
      else begin
        if (ex && op == 5 && dne && dh == oldp) void'(dq.pop_front());
        if (done_push && !df) dq.push_back(int'(done_push_pnr));
        if (tx_take && txne) void'(txq.pop_front());
        if (ex && op == 6 && !txf) txq.push_back(oldp);
      end
      if (ex && op == 1) begin
        if (ok && !over) begin
          m_al[lf] = 1; m_pg[lf] = qp; m_used += qp;
          m_pnr = lf; m_fail = 0; m_pend = 0;
        end else begin m_fail = 1; m_pend = !over; m_pp = qp; end
      end else if (pgo) begin
        m_al[lf] = 1; m_pg[lf] = qp; m_used += qp;
        m_pnr = lf; m_fail = 0; m_pend = 0;
      end else if (ex && op == 2) begin
        for (int i = 0; i < NP; i++) m_al[i] = 0;
        m_used = 0; m_pnr = 0; m_fail = 0; m_pend = 0;
      end else if (pnr_we) m_pnr = int'(pnr_wdata);
    end
  end

  // every-clock comparison, sampled away from the active edge
  always @(negedge clk) begin
    if (cmp_en && rst_n && !finished) begin
      logic [15:0] efp;
      efp = rxq.size() > 0 ? {2'b00, 6'(rxq[0]), 8'h00} : 16'h8000;
      efp |= dq.size() > 0 ? {10'b0, 6'(dq[0])} : 16'h0080;
      chk("R1 busy", int'(cmd_busy), int'(m_busy != 0));
      chk("R2 alloc_result", int'(alloc_result), int'({m_fail, 9'b0, 6'(m_pnr)}));
      chk("R11 fifo_ports", int'(fifo_ports), int'(efp));
      chk("R8 tx_req_valid", int'(tx_req_valid), int'(txq.size() > 0));
      chk("R8 tx_req_pnr", int'(tx_req_pnr), txq.size() > 0 ? txq[0] : 0);
      chk("R4 alloc_done", int'(alloc_done), int'(m_done));
      if (alloc_done) done_seen++;
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic do_cmd(input logic [2:0] op, input logic [4:0] sz);
    cmd_wdata = {op, sz}; cmd_we = 1;
    @(negedge clk); cmd_we = 0;
    while (cmd_busy) @(negedge clk);
  endtask
  task automatic set_pnr(input logic [5:0] p);
    pnr_wdata = p; pnr_we = 1; @(negedge clk); pnr_we = 0;
  endtask
  task automatic rx_in(input logic [5:0] p);
    rx_push_pnr = p; rx_push = 1; @(negedge clk); rx_push = 0;
  endtask
  task automatic done_in(input logic [5:0] p);
    done_push_pnr = p; done_push = 1; @(negedge clk); done_push = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1; fails++; tests++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int ds;
    repeat (3) @(negedge clk);
    rst_n = 1; cmp_en = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 busy", int'(cmd_busy), 0);
    chk("R12 result", int'(alloc_result), 0);
    chk("R12 fifo_ports", int'(fifo_ports), 16'h8080);
    chk("R12 tx_valid", int'(tx_req_valid), 0);

    // R2 grants lowest numbers; R3 page budget failure
    do_cmd(3'd1, 5'd2);  chk("R2 first grant", int'(alloc_result), 16'h0000);
    do_cmd(3'd1, 5'd7);  chk("R2 second grant", int'(alloc_result), 16'h0001);
    do_cmd(3'd1, 5'd7);  chk("R2 third grant", int'(alloc_result), 16'h0002);
    do_cmd(3'd1, 5'd7);  chk("R3 page budget fail", int'(alloc_result), 16'h8002);
    chk("R3 no done on fail", done_seen, 0);

    // R4 pending grant after a release by number (R7)
    set_pnr(6'd1);
    do_cmd(3'd5, 5'd0);
    repeat (2) @(negedge clk);
    chk("R4 pending granted", int'(alloc_result), 16'h0001);
    chk("R4 one done pulse", done_seen, 1);

    // R5 drop without release, R6 drop with release, R11 layout
    rx_in(6'd1); rx_in(6'd0);
    chk("R11 rx head", int'(fifo_ports), 16'h0180);
    do_cmd(3'd3, 5'd0);  chk("R5 rx drop", int'(fifo_ports), 16'h0080);
    do_cmd(3'd4, 5'd0);  chk("R6 rx drop free", int'(fifo_ports), 16'h8080);
    do_cmd(3'd1, 5'd0);  chk("R6 freed reused", int'(alloc_result), 16'h0000);
    do_cmd(3'd1, 5'd0);  chk("R5 dropped stays allocated", int'(alloc_result), 16'h0003);

    // R8 transmit queue, R7 completion head removal
    done_in(6'd3);
    chk("R11 done head", int'(fifo_ports), 16'h8003);
    do_cmd(3'd6, 5'd0);
    chk("R8 tx valid", int'(tx_req_valid), 1);
    chk("R8 tx pnr", int'(tx_req_pnr), 3);
    tx_take = 1; @(negedge clk); tx_take = 0;
    chk("R8 tx taken", int'(tx_req_valid), 0);
    do_cmd(3'd5, 5'd0);  chk("R7 done popped", int'(fifo_ports), 16'h8080);
    do_cmd(3'd1, 5'd0);  chk("R7 released reused", int'(alloc_result), 16'h0003);

    // R9 transmit-side reset keeps allocations
    do_cmd(3'd6, 5'd0); do_cmd(3'd6, 5'd0); done_in(6'd2);
    do_cmd(3'd7, 5'd0);
    chk("R9 tx cleared", int'(tx_req_valid), 0);
    chk("R9 done cleared", int'(fifo_ports), 16'h8080);
    do_cmd(3'd1, 5'd0);  chk("R9 allocs kept", int'(alloc_result), 16'h0004);

    // R3 oversize request fails and is not held
    do_cmd(3'd1, 5'd8);  chk("R3 oversize fail", int'(alloc_result), 16'h8004);
    ds = done_seen;
    set_pnr(6'd4); do_cmd(3'd5, 5'd0);
    repeat (3) @(negedge clk);
    chk("R3 oversize not pending", done_seen, ds);

    // R13 receive queue depth
    for (int i = 0; i < 9; i++) rx_in(6'(i));
    chk("R13 rx head", int'(fifo_ports), 16'h0080);
    for (int i = 0; i < 7; i++) do_cmd(3'd3, 5'd0);
    chk("R13 last kept", int'(fifo_ports), 16'h0780);
    do_cmd(3'd3, 5'd0);
    chk("R13 ninth dropped", int'(fifo_ports), 16'h8080);

    // R10 full unit reset
    rx_in(6'd5); done_in(6'd5); set_pnr(6'd5); do_cmd(3'd6, 5'd0);
    do_cmd(3'd2, 5'd0);
    chk("R10 result", int'(alloc_result), 0);
    chk("R10 fifos", int'(fifo_ports), 16'h8080);
    chk("R10 tx", int'(tx_req_valid), 0);
    do_cmd(3'd1, 5'd7); do_cmd(3'd1, 5'd7); do_cmd(3'd1, 5'd7);
    chk("R10 all freed", int'(alloc_result), 16'h0002);
    do_cmd(3'd1, 5'd7);  chk("R3 budget fail again", int'(alloc_result), 16'h8002);
    ds = done_seen;
    do_cmd(3'd2, 5'd0);
    repeat (4) @(negedge clk);
    chk("R10 pending cancelled", done_seen, ds);

    // R3 packet numbers exhausted
    for (int i = 0; i < 8; i++) do_cmd(3'd1, 5'd0);
    chk("R2 eighth grant", int'(alloc_result), 16'h0007);
    do_cmd(3'd1, 5'd0);  chk("R3 no packet fail", int'(alloc_result), 16'h8007);

    // R1 write during busy ignored
    cmd_wdata = 8'h60; cmd_we = 1; @(negedge clk);
    cmd_wdata = 8'h20; @(negedge clk); cmd_we = 0;
    while (cmd_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R1 busy write ignored", int'(alloc_result), 16'h8007);
    chk("R1 idle after", int'(cmd_busy), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule